// File: doc/BRIEF.md
# Retentive Regulator Loop Controller

This block is the digital heart of a fast-waking voltage regulator. On every enabled clock it takes a single comparator decision, which says whether the regulated voltage is below or above its target. It adds that decision to a saturating up/down integrator. The most significant bits of the integrator drive the code of a resistive DAC. The low-order integrator bits are not passed on, so the ripple that loop delay causes does not reach the DAC. The comparator, DAC, pass device and decoupling capacitor are analog parts outside the block. They appear here only as one input bit and one code output.

A power-enable input gates the loop. When the enable is low, the integrator and the DAC code are frozen and kept, the drive to the pass device is forced low, and the code-valid flag drops. When the enable returns, the kept code is already on the output. The loop therefore resumes from its last operating point and not from a reset value. Only the synchronous reset loads the programmable mid-scale start value.

A two-state controller sequences the block. State SLEEP is entered from reset and through transition GO_SLEEP, taken on any clock where the enable is low. State RUN is entered through transition GO_RUN, taken on any clock where the enable is high. Each state holds while its condition persists.

Top module: `retreg_loop_ctrl`

## Requirements
- R1: A synchronous reset loads the integrator with ACC_INIT (default 2048). It sets code_out to ACC_INIT shifted right by 5 (default 64), clears code_valid and clears drive_on.
- R2: On each clock with pwr_en high, a cmp_low of 1 raises the integrator by one and a cmp_low of 0 lowers it by one.
- R3: The integrator saturates at 4095 and at 0 and never wraps.
- R4: code_out is bits 11 down to 5 of the integrator. The five lowest bits are discarded. code_out takes the integrator value one clock after the integrator changes.
- R5: On clocks with pwr_en low, the integrator holds its value and cmp_low has no effect.
- R6: code_out holds its retained value while the controller is in SLEEP. code_valid is 1 exactly when the controller is in RUN, one clock after pwr_en is sampled.
- R7: drive_on is 0 whenever the controller is in SLEEP, so the pass device gate is pulled low while the block is off.
- R8: On the first clock after pwr_en returns high, code_out equals the code held before power-off, not the reset code.
- R9: Toggling pwr_en never resets the integrator. Integration resumes from the retained value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Loop clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_en | input | 1 | Regulator enable; low gates the loop |
| cmp_low | input | 1 | Comparator decision: 1 means the output is below target (count up) |
| code_out | output | 7 | DAC code, the upper integrator bits |
| code_valid | output | 1 | High while the loop runs |
| drive_on | output | 1 | Pass-device drive enable; low forces the gate off |

## Verification
Two functions can fall in the same cycle: the last integrator step before power-off and the final capture of the code into the output register. The bench drops pwr_en on the cycle where the integrator has just crossed a multiple of 32, so the frozen code must include that last step. A behavioural model in the bench tracks the integrator, the code and the run flag every cycle and is compared at each falling edge. The bench also toggles the enable on every cycle, so that wake and sleep transitions coincide with active integration.

// File: rtl/retreg_pkg.sv
package retreg_pkg;
    typedef enum logic [0:0] {
        ST_SLEEP = 1'b0,
        ST_RUN   = 1'b1
    } loop_state_t;
endpackage

// File: rtl/retreg_fsm.sv
module retreg_fsm
    import retreg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pwr_en,
    output logic running
);
    loop_state_t state_q, state_d;

    // Next-state logic: GO_RUN and GO_SLEEP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SLEEP: if (pwr_en)  state_d = ST_RUN;
            ST_RUN:   if (!pwr_en) state_d = ST_SLEEP;
            default:  state_d = ST_SLEEP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_SLEEP;
        else     state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_RUN:   running = 1'b1;
            ST_SLEEP: running = 1'b0;
            default:  running = 1'b0;
        endcase
    end

    assert_run_follows_en_R6: assert property (@(posedge clk) disable iff (rst)
        pwr_en |=> running);
    assert_sleep_follows_en_R7: assert property (@(posedge clk) disable iff (rst)
        !pwr_en |=> !running);
endmodule

// File: rtl/retreg_accum.sv
module retreg_accum #(
    parameter int ACC_W    = 12,
    parameter int ACC_INIT = 2048
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             up,
    output logic [ACC_W-1:0] acc
);
    localparam logic [ACC_W-1:0] ACC_MAX  = {ACC_W{1'b1}};
    localparam logic [ACC_W-1:0] ACC_MIN  = '0;
    localparam logic [ACC_W-1:0] INIT_VAL = ACC_W'(ACC_INIT);

    logic [ACC_W-1:0] acc_q, acc_d;

    always_comb begin
        acc_d = acc_q;
        if (en) begin
            if (up && acc_q != ACC_MAX)       acc_d = acc_q + 1'b1;
            else if (!up && acc_q != ACC_MIN) acc_d = acc_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= INIT_VAL;
        else     acc_q <= acc_d;
    end

    assign acc = acc_q;

    assert_hold_when_off_R5: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(acc_q));
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (en && up && acc_q == ACC_MAX) |=> acc_q == ACC_MAX);
    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (rst)
        (en && !up && acc_q == ACC_MIN) |=> acc_q == ACC_MIN);
    assert_step_up_R2: assert property (@(posedge clk) disable iff (rst)
        (en && up && acc_q != ACC_MAX) |=> acc_q == $past(acc_q) + 1'b1);
    assert_step_down_R2: assert property (@(posedge clk) disable iff (rst)
        (en && !up && acc_q != ACC_MIN) |=> acc_q == $past(acc_q) - 1'b1);
endmodule

// File: rtl/retreg_code_reg.sv
module retreg_code_reg #(
    parameter int ACC_W    = 12,
    parameter int CODE_W   = 7,
    parameter int ACC_INIT = 2048
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd,
    input  logic [ACC_W-1:0]  acc,
    output logic [CODE_W-1:0] code
);
    localparam int DROP_W = ACC_W - CODE_W;
    localparam logic [ACC_W-1:0] INIT_VAL = ACC_W'(ACC_INIT);

    logic [CODE_W-1:0] code_q;

    always_ff @(posedge clk) begin
        if (rst)      code_q <= INIT_VAL[ACC_W-1:DROP_W];
        else if (upd) code_q <= acc[ACC_W-1:DROP_W];
    end

    assign code = code_q;

    assert_code_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(code_q));
    assert_code_track_R4: assert property (@(posedge clk) disable iff (rst)
        upd |=> code_q == $past(acc[ACC_W-1:DROP_W]));
endmodule

// File: rtl/retreg_loop_ctrl.sv
module retreg_loop_ctrl #(
    parameter int ACC_W    = 12,
    parameter int CODE_W   = 7,
    parameter int ACC_INIT = 2048
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_en,
    input  logic              cmp_low,
    output logic [CODE_W-1:0] code_out,
    output logic              code_valid,
    output logic              drive_on
);
    logic             running;
    logic [ACC_W-1:0] acc;

    retreg_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .pwr_en  (pwr_en),
        .running (running)
    );

    retreg_accum #(.ACC_W(ACC_W), .ACC_INIT(ACC_INIT)) u_accum (
        .clk (clk),
        .rst (rst),
        .en  (pwr_en),
        .up  (cmp_low),
        .acc (acc)
    );

    retreg_code_reg #(.ACC_W(ACC_W), .CODE_W(CODE_W), .ACC_INIT(ACC_INIT)) u_code (
        .clk  (clk),
        .rst  (rst),
        .upd  (running),
        .acc  (acc),
        .code (code_out)
    );

    assign code_valid = running;
    assign drive_on   = running;

    assert_gate_low_off_R7: assert property (@(posedge clk) disable iff (rst)
        !pwr_en |=> !drive_on);
    assert_wake_code_kept_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_en) |=> code_out == $past(code_out));
endmodule

// File: tb/retreg_loop_ctrl_bench.sv
module retreg_loop_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwr_en = 1'b0;
    logic       cmp_low = 1'b0;
    logic [6:0] code_out;
    logic       code_valid;
    logic       drive_on;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string phase = "R1";

    int m_acc = 2048;
    int m_code = 64;
    bit m_run = 1'b0;

    always #4 clk = ~clk;

    retreg_loop_ctrl u_retreg_loop_ctrl (
        .clk(clk), .rst(rst), .pwr_en(pwr_en), .cmp_low(cmp_low),
        .code_out(code_out), .code_valid(code_valid), .drive_on(drive_on)
    );

    // Behavioural reference model
    always @(posedge clk) begin
        int n_acc;
        if (rst) begin
            m_acc = 2048; m_code = 64; m_run = 1'b0;
        end else begin
            n_acc = m_acc;
            if (pwr_en) n_acc = cmp_low ? ((m_acc < 4095) ? m_acc + 1 : 4095)
                                        : ((m_acc > 0) ? m_acc - 1 : 0);
            if (m_run) m_code = m_acc / 32;
            m_run = pwr_en;
            m_acc = n_acc;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            check(phase, "code_out R4", int'(code_out), m_code);
            check(phase, "code_valid R6", int'(code_valid), int'(m_run));
            check(phase, "drive_on R7", int'(drive_on), int'(m_run));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic run(input int n, input bit en, input bit up);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pwr_en = en; cmp_low = up;
        end
    endtask

    initial begin
        int saved;
        repeat (4) @(negedge clk);
        check("R1", "reset code", int'(code_out), 64);
        check("R1", "reset valid", int'(code_valid), 0);
        check("R1", "reset drive", int'(drive_on), 0);
        @(negedge clk); rst = 1'b0;

        phase = "R2";
        run(100, 1'b1, 1'b1);
        for (int i = 0; i < 60; i++) run(1, 1'b1, i[0]);
        run(300, 1'b1, 1'b0);

        phase = "R3";
        run(4300, 1'b1, 1'b1);
        @(negedge clk);
        check("R3", "saturated high code", int'(code_out), 127);
        run(4300, 1'b1, 1'b0);
        @(negedge clk);
        check("R3", "saturated low code", int'(code_out), 0);

        // Coincident last step and code capture: stop right after a 32 crossing
        phase = "R4";
        run(1024, 1'b1, 1'b1);
        run(1, 1'b1, 1'b1);
        saved = 0;
        phase = "R5";
        run(50, 1'b0, 1'b1);
        for (int i = 0; i < 40; i++) run(1, 1'b0, i[1]);
        @(negedge clk);
        saved = int'(code_out);
        check("R5", "code frozen after sleep", saved, 32);
        check("R6", "valid low while off", int'(code_valid), 0);
        check("R7", "drive low while off", int'(drive_on), 0);

        phase = "R8";
        run(1, 1'b1, 1'b0);
        @(negedge clk);
        check("R8", "code retained at wake", int'(code_out), saved);
        check("R8", "valid at wake", int'(code_valid), 1);

        phase = "R9";
        for (int i = 0; i < 200; i++) run(1, i[0], 1'b1);
        run(3, 1'b0, 1'b0);
        @(negedge clk);
        check("R9", "no reset on toggling", int'(code_out), m_code);
        check("R9", "code moved up not reset", int'(code_out > 7'd32), 1);

        phase = "R2";
        run(500, 1'b1, 1'b0);
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule